// File: doc/BRIEF.md
# Privilege Level Return Controller

This block tracks which of four privilege levels (0 lowest, 3 highest) a processor core is running at, and carries out exception-return requests. Each of levels 1 to 3 owns a saved return address and a saved status word. Each of levels 0 to 3 owns a stack-pointer bank. Software reaches all of these through a small system-register port. When the return strobe fires, the block reads the saved status of the current level and checks the target it encodes. If the target is allowed, the block moves to it in one clock: it loads the new program counter and the four interrupt-class mask bits, and picks the active stack-pointer bank.

Two straps say whether levels 2 and 3 exist. Levels 0 and 1 always exist. After reset the block starts at the highest level present. A return can only move to an equal or lower level that exists. Any other request sets a one-cycle illegal flag and leaves the architectural state as it was.

Top module: `priv_return_ctrl`

## Requirements
- R1: While reset is held and on the first cycle after it, the level is 3 if `strap_l3` is set, else 2 if `strap_l2` is set, else 1. At that point `pc` is 0, `irq_mask` is 4'hF and `sp_sel` equals the level.
- R2: A read with `sys_kind`=3 returns the current level in bits [3:2] and zero in all other bits, so level 2 reads as 8.
- R3: A legal return at level L loads `pc` from L's return-address register (`sys_kind`=0). It loads `irq_mask` from bits [9:6] of L's status register (`sys_kind`=1) and the level from status bits [3:2]. All of these are visible in the cycle after the strobe.
- R4: After a legal return, `sp_sel` equals the new level when status bit 0 is 1, and 0 when that bit is 0. `sp_val` always shows the stack bank that `sp_sel` names.
- R5: A return is legal only when all of these hold: status bits 4 and 1 are zero; the target is no higher than the current level; the target level exists (2 needs `strap_l2`, 3 needs `strap_l3`); and a target of 0 has status bit 0 clear.
- R6: A return requested at level 0 is always illegal.
- R7: An illegal return raises `ret_illegal` for exactly the one cycle after the strobe. The level, `pc`, `irq_mask` and `sp_sel` do not change.
- R8: Level 0 has no return-address or status register. Writes with `sys_lvl`=0 and `sys_kind` 0 or 1 are ignored, and reads of them return 0. A status register keeps only bits [9:0] and reads zero above them.
- R9: Without a return strobe, the level, `pc`, `irq_mask` and `sp_sel` hold their values, even while system-register writes take place.
- R10: Writes with `sys_kind`=2 set the stack bank selected by `sys_lvl` for any of the four levels. That bank reads back through `sys_rdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| strap_l2 | input | 1 | Level 2 exists |
| strap_l3 | input | 1 | Level 3 exists |
| ret_req | input | 1 | Exception-return strobe |
| sys_we | input | 1 | System-register write enable |
| sys_kind | input | 2 | 0 return address, 1 status, 2 stack bank, 3 level register |
| sys_lvl | input | 2 | Level whose register is accessed |
| sys_wdata | input | AW | Write data |
| sys_rdata | output | AW | Read data, combinational |
| pc | output | AW | Program counter after the latest return |
| cur_lvl | output | 2 | Current privilege level |
| irq_mask | output | 4 | Interrupt-class mask bits |
| sp_sel | output | 2 | Active stack bank |
| sp_val | output | AW | Contents of the active stack bank |
| ret_illegal | output | 1 | One-cycle flag for a rejected return |

## Verification
A wrong internal level shows up at once on `cur_lvl`, on the level-register read and on `sp_sel`. It also changes which return-address and status pair the next return uses. So a bad level produces a wrong `pc` or a wrong legality verdict on the very next strobe. The bench therefore sweeps every strap setting, every starting level and all 32 mode codes. It checks the outputs in the cycle right after each strobe, so a stale stack-choice bit or a mask loaded from the wrong bits is caught within one return.

// File: rtl/priv_return_ctrl.sv
module priv_return_ctrl #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          strap_l2,
  input  logic          strap_l3,
  input  logic          ret_req,
  input  logic          sys_we,
  input  logic [1:0]    sys_kind,
  input  logic [1:0]    sys_lvl,
  input  logic [AW-1:0] sys_wdata,
  output logic [AW-1:0] sys_rdata,
  output logic [AW-1:0] pc,
  output logic [1:0]    cur_lvl,
  output logic [3:0]    irq_mask,
  output logic [1:0]    sp_sel,
  output logic [AW-1:0] sp_val,
  output logic          ret_illegal
);
  localparam int SW  = 10;
  localparam int NLV = 4;

  logic [AW-1:0] ra_q  [NLV];
  logic [SW-1:0] st_q  [NLV];
  logic [AW-1:0] stk_q [NLV];
  logic [1:0]    lvl_q;
  logic [AW-1:0] pc_q;
  logic [3:0]    msk_q;
  logic          own_q;
  logic          ill_q;

  logic [3:0]    present;
  logic [1:0]    boot_lvl;
  logic [SW-1:0] st_cur;
  logic [1:0]    tgt;
  logic          legal;

  assign present  = {strap_l3, strap_l2, 2'b11};
  assign boot_lvl = strap_l3 ? 2'd3 : (strap_l2 ? 2'd2 : 2'd1);

  assign st_cur = st_q[lvl_q];
  assign tgt    = st_cur[3:2];
  assign legal  = (lvl_q != 2'd0) && !st_cur[4] && !st_cur[1]
                  && (tgt <= lvl_q) && present[tgt]
                  && !((tgt == 2'd0) && st_cur[0]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lvl_q <= boot_lvl;
      pc_q  <= '0;
      msk_q <= 4'hF;
      own_q <= 1'b1;
      ill_q <= 1'b0;
      for (int i = 0; i < NLV; i++) begin
        ra_q[i]  <= '0;
        st_q[i]  <= '0;
        stk_q[i] <= '0;
      end
    end else begin
      ill_q <= ret_req && !legal;
      if (ret_req && legal) begin
        lvl_q <= tgt;
        pc_q  <= ra_q[lvl_q];
        msk_q <= st_cur[9:6];
        own_q <= st_cur[0];
      end
      if (sys_we) begin
        case (sys_kind)
          2'd0: if (sys_lvl != 2'd0) ra_q[sys_lvl] <= sys_wdata;
          2'd1: if (sys_lvl != 2'd0) st_q[sys_lvl] <= sys_wdata[SW-1:0];
          2'd2: stk_q[sys_lvl] <= sys_wdata;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (sys_kind)
      2'd0:    sys_rdata = ra_q[sys_lvl];
      2'd1:    sys_rdata = {{(AW-SW){1'b0}}, st_q[sys_lvl]};
      2'd2:    sys_rdata = stk_q[sys_lvl];
      default: sys_rdata = {{(AW-4){1'b0}}, lvl_q, 2'b00};
    endcase
  end

  assign sp_sel      = own_q ? lvl_q : 2'd0;
  assign sp_val      = stk_q[sp_sel];
  assign pc          = pc_q;
  assign cur_lvl     = lvl_q;
  assign irq_mask    = msk_q;
  assign ret_illegal = ill_q;
endmodule

// File: rtl/priv_return_chk.sv
module priv_return_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          strap_l2,
  input logic          strap_l3,
  input logic          ret_req,
  input logic [AW-1:0] pc,
  input logic [1:0]    cur_lvl,
  input logic [3:0]    irq_mask,
  input logic [1:0]    sp_sel,
  input logic          ret_illegal
);
  AST_LVL_PRESENT: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_lvl != 2'd3 || strap_l3) && (cur_lvl != 2'd2 || strap_l2)); // R5
  AST_NO_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
    ret_req |=> cur_lvl <= $past(cur_lvl)); // R5
  AST_ILLEGAL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ret_illegal |-> (cur_lvl == $past(cur_lvl) && pc == $past(pc)
                     && irq_mask == $past(irq_mask) && sp_sel == $past(sp_sel))); // R7
  AST_ILLEGAL_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    ret_illegal |-> $past(ret_req)); // R7
  AST_LVL0_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_req && cur_lvl == 2'd0) |=> ret_illegal); // R6
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !ret_req |=> ($stable(cur_lvl) && $stable(pc) && $stable(irq_mask) && $stable(sp_sel))); // R9
  AST_STACK_MAP: assert property (@(posedge clk) disable iff (!rst_n)
    sp_sel == 2'd0 || sp_sel == cur_lvl); // R4
endmodule

bind priv_return_ctrl priv_return_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .strap_l2(strap_l2), .strap_l3(strap_l3),
  .ret_req(ret_req), .pc(pc), .cur_lvl(cur_lvl), .irq_mask(irq_mask),
  .sp_sel(sp_sel), .ret_illegal(ret_illegal)
);

// File: tb/tb_priv_return_ctrl.sv
`timescale 1ns/1ps
module tb_priv_return_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        strap_l2 = 1'b1, strap_l3 = 1'b1;
  logic        ret_req = 1'b0, sys_we = 1'b0;
  logic [1:0]  sys_kind = 2'd0, sys_lvl = 2'd0;
  logic [31:0] sys_wdata = '0;
  logic [31:0] sys_rdata, pc, sp_val;
  logic [1:0]  cur_lvl, sp_sel;
  logic [3:0]  irq_mask;
  logic        ret_illegal;

  int total = 0, bad = 0, cyc = 0;
  bit done = 0;

  always #4 clk = ~clk;

  priv_return_ctrl #(.AW(32)) dut (
    .clk(clk), .rst_n(rst_n), .strap_l2(strap_l2), .strap_l3(strap_l3),
    .ret_req(ret_req), .sys_we(sys_we), .sys_kind(sys_kind), .sys_lvl(sys_lvl),
    .sys_wdata(sys_wdata), .sys_rdata(sys_rdata), .pc(pc), .cur_lvl(cur_lvl),
    .irq_mask(irq_mask), .sp_sel(sp_sel), .sp_val(sp_val), .ret_illegal(ret_illegal)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      total++; bad++;
      $display("FAIL R9 watchdog act=%0d exp=<150000", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic do_reset(input bit l2, input bit l3);
    @(negedge clk);
    rst_n = 1'b0; strap_l2 = l2; strap_l3 = l3;
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wr(input logic [1:0] k, input logic [1:0] l, input logic [31:0] d);
    @(negedge clk);
    sys_we = 1'b1; sys_kind = k; sys_lvl = l; sys_wdata = d;
    @(negedge clk);
    sys_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] k, input logic [1:0] l, output logic [31:0] d);
    sys_kind = k; sys_lvl = l;
    #1 d = sys_rdata;
  endtask

  task automatic do_ret();
    @(negedge clk); ret_req = 1'b1;
    @(negedge clk); ret_req = 1'b0;
  endtask

  function automatic bit exp_legal(input int L, input logic [4:0] m, input bit l2, input bit l3);
    int t;
    t = int'(m[3:2]);
    if (L == 0) return 0;
    if (m[4] || m[1]) return 0;
    if (t > L) return 0;
    if (t == 3 && !l3) return 0;
    if (t == 2 && !l2) return 0;
    if (t == 0 && m[0]) return 0;
    return 1;
  endfunction

  initial begin
    logic [31:0] r;
    for (int cfg = 0; cfg < 4; cfg++) begin
      bit l2, l3;
      int top;
      l2 = cfg[0]; l3 = cfg[1];
      top = l3 ? 3 : (l2 ? 2 : 1);
      do_reset(l2, l3);
      chk("R1 level", {30'd0, cur_lvl}, top);
      chk("R1 pc", pc, 32'd0);
      chk("R1 mask", {28'd0, irq_mask}, 32'hF);
      chk("R1 sp_sel", {30'd0, sp_sel}, top);
      chk("R1 illegal", {31'd0, ret_illegal}, 32'd0);
      rd(2'd3, 2'd0, r);
      chk("R2 level reg", r, top << 2);

      for (int L = 1; L <= top; L++) begin
        if ((L == 2 && !l2) || (L == 3 && !l3)) continue;
        for (int mi = 0; mi < 32; mi++) begin
          logic [4:0]  m;
          logic [3:0]  mk;
          logic [31:0] addr, ppc;
          logic [3:0]  pmask;
          int t, esel;
          bit ok;
          m = mi[4:0];
          mk = mi[3:0] ^ 4'hA;
          addr = 32'hA000_0000 + (cfg << 12) + (L << 8) + mi;
          do_reset(l2, l3);
          for (int b = 0; b < 4; b++) wr(2'd2, b[1:0], 32'h1000 * (b + 1));
          ppc = 32'd0; pmask = 4'hF;
          if (L != top) begin
            wr(2'd1, top[1:0], (L << 2) | 1);
            wr(2'd0, top[1:0], 32'h100 + L);
            do_ret();
            ppc = 32'h100 + L; pmask = 4'h0;
          end
          wr(2'd1, L[1:0], {22'd0, mk, 1'b1, m});
          wr(2'd0, L[1:0], addr);
          do_ret();
          ok = exp_legal(L, m, l2, l3);
          t = int'(m[3:2]);
          if (ok) begin
            esel = m[0] ? t : 0;
            chk("R3 level", {30'd0, cur_lvl}, t);
            chk("R3 pc", pc, addr);
            chk("R3 mask", {28'd0, irq_mask}, {28'd0, mk});
            chk("R4 sp_sel", {30'd0, sp_sel}, esel);
            chk("R4 sp_val", sp_val, 32'h1000 * (esel + 1));
            chk("R5 legal flag", {31'd0, ret_illegal}, 32'd0);
            rd(2'd3, 2'd0, r);
            chk("R2 level reg", r, t << 2);
          end else begin
            chk("R5 R7 flag", {31'd0, ret_illegal}, 32'd1);
            chk("R7 level", {30'd0, cur_lvl}, L);
            chk("R7 pc", pc, ppc);
            chk("R7 mask", {28'd0, irq_mask}, {28'd0, pmask});
            chk("R7 sp_sel", {30'd0, sp_sel}, L);
          end
          @(negedge clk);
          chk("R7 pulse", {31'd0, ret_illegal}, 32'd0);
        end
      end
    end

    do_reset(1'b1, 1'b1);
    wr(2'd1, 2'd3, 32'd0);
    wr(2'd0, 2'd3, 32'h55);
    do_ret();
    chk("R3 to level0", {30'd0, cur_lvl}, 32'd0);
    chk("R4 sp_sel level0", {30'd0, sp_sel}, 32'd0);
    do_ret();
    chk("R6 flag", {31'd0, ret_illegal}, 32'd1);
    chk("R6 level", {30'd0, cur_lvl}, 32'd0);
    chk("R6 pc", pc, 32'h55);
    wr(2'd0, 2'd0, 32'hDEAD_BEEF);
    rd(2'd0, 2'd0, r);
    chk("R8 ra level0", r, 32'd0);
    wr(2'd1, 2'd0, 32'h3FF);
    rd(2'd1, 2'd0, r);
    chk("R8 status level0", r, 32'd0);
    wr(2'd1, 2'd2, 32'hFFFF_FFFF);
    rd(2'd1, 2'd2, r);
    chk("R8 status width", r, 32'h3FF);
    for (int b = 0; b < 4; b++) begin
      wr(2'd2, b[1:0], 32'h7700_0000 | b);
      rd(2'd2, b[1:0], r);
      chk("R10 stack bank", r, 32'h7700_0000 | b);
    end
    chk("R10 sp_val", sp_val, 32'h7700_0000);
    wr(2'd3, 2'd0, 32'hC);
    repeat (3) @(negedge clk);
    chk("R9 level", {30'd0, cur_lvl}, 32'd0);
    chk("R9 pc", pc, 32'h55);
    chk("R9 mask", {28'd0, irq_mask}, 32'd0);
    rd(2'd3, 2'd0, r);
    chk("R9 level reg", r, 32'd0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule